// File: doc/BRIEF.md
# Write-Only Peripheral Shadow Snooper

This block sits passively on a host I/O bus and rebuilds the internal register state of two peripherals that cannot be read back: an FM sound generator, addressed through an index port and a data port, and a video display processor, addressed through a two-byte control port, a palette port, an indirect register port and a video memory data port. For every register it keeps only the latest byte written, so a save-state or debug routine can later recover the whole setup without knowing the order of the writes. The video memory access pointer is followed as the host programs it and steps it, but the memory contents themselves are not copied.

The host reads the copies through two private ports: a write to the select port sets a byte offset in the shadow space, and each read of the readback port returns the byte at that offset and steps the offset by one. The shadow space is laid out as FM registers at 0x00–0x3F, video registers at 0x40–0x7F, palette bytes at 0x80–0x9F (entry i has its first byte at 0x80+2i and its second at 0x81+2i), the pointer low byte at 0xA0 and the pointer high bits at 0xA1. Offsets from 0xA2 up hold nothing. The default private ports are 0x5E (select) and 0x5F (readback).

Top module: `snoop_shadow_top`

## Requirements
- R1: After reset every shadow byte, the video pointer and the readback offset are zero, so a readback without a prior select returns offset 0.
- R2: A write to port 0x7C sets the FM index; each later write to 0x7D stores its byte at offset index, a repeated write replacing the older value; an index of 64 or more makes 0x7D writes change nothing.
- R3: Port 0x99 takes bytes in pairs; when the second byte has bit 7 set, the first byte is stored in video register number second[5:0], read back at 0x40 plus that number.
- R4: When the second byte on port 0x99 has bit 7 clear, the pointer becomes {second[5:0], first}; bit 6 of the second byte has no effect.
- R5: A read of port 0x99 returns the pair sequence to its first byte.
- R6: Each write or read of port 0x98 adds one to the 14-bit pointer, 0x3FFF stepping to 0x0000.
- R7: Port 0x9A takes byte pairs; the pair is stored in palette entry reg16[3:0] and then reg16[3:0] steps by one modulo 16 with reg16[7:4] kept; any write to video register 16 returns the palette sequence to its first byte.
- R8: A write to port 0x9B stores its byte in video register reg17[5:0]; after it reg17[5:0] steps by one modulo 64 unless reg17 bit 7 is set, reg17[7:6] kept.
- R9: A write to the select port loads the offset; a read of the readback port returns the byte at the offset in that same cycle and then adds one to the offset, 0xFF stepping to 0x00; offsets 0xA2 to 0xFF read 0xFF.
- R10: The readback enable is high only during a read of the readback port, and writes to ports the block does not decode change no shadow byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port number of the current access |
| io_wdata | input | 8 | Byte carried by a write |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_rd | input | 1 | One-cycle I/O read strobe |
| rd_data | output | 8 | Shadow byte at the current offset |
| rd_en | output | 1 | High while the block answers a readback |

## Verification
The hardest states to reach are the ones where two byte sequences are interleaved or cut short: a palette pair broken by a write to register 16, and a control pair broken by a read of the control port. The stimulus leaves each sequence half finished on purpose, then sends the interrupting access, then a fresh pair whose bytes would land at a different register or pointer value if the phase had not been cleared. Wrap points (the 0x3FFF pointer, palette entry 15, offset 0xFF) are reached by first loading the value just below the wrap through the normal ports.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;
   typedef logic [7:0] byte_t;
   // video register numbers whose contents steer the palette and indirect ports
   localparam int VREG_PAL_IDX = 16;
   localparam int VREG_IND_IDX = 17;
   localparam byte_t EMPTY_BYTE = 8'hFF;
endpackage

// File: rtl/fm_shadow.sv
`timescale 1ns/1ps
module fm_shadow
   import snoop_pkg::*;
#(
   parameter int   IDX_W    = 6,
   parameter byte_t PORT_IDX = 8'h7C,
   parameter byte_t PORT_DAT = 8'h7D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  byte_t            addr,
   input  byte_t            wdata,
   input  logic [IDX_W-1:0] rd_ofs,
   output byte_t            rd_byte
);
   localparam int DEPTH = 1 << IDX_W;

   byte_t idx_q;
   byte_t mem_q [DEPTH];
   logic  idx_ok;

   assign idx_ok  = ({1'b0, idx_q} < 9'(DEPTH));
   assign rd_byte = mem_q[rd_ofs];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr) begin
         if (addr == PORT_IDX)
            idx_q <= wdata;
         else if (addr == PORT_DAT && idx_ok)
            mem_q[idx_q[IDX_W-1:0]] <= wdata;
      end
   end
endmodule

// File: rtl/vdp_shadow.sv
`timescale 1ns/1ps
module vdp_shadow
   import snoop_pkg::*;
#(
   parameter int    REG_W      = 6,
   parameter int    PAL_N      = 16,
   parameter int    PTR_W      = 14,
   parameter bit    PTR_RD_INC = 1'b1,
   parameter byte_t PORT_VRAM  = 8'h98,
   parameter byte_t PORT_CTL   = 8'h99,
   parameter byte_t PORT_PAL   = 8'h9A,
   parameter byte_t PORT_IND   = 8'h9B,
   localparam int   PAL_B      = 2 * PAL_N,
   localparam int   PAL_OFS_W  = $clog2(PAL_B)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 rd,
   input  byte_t                addr,
   input  byte_t                wdata,
   input  logic [REG_W-1:0]     reg_ofs,
   output byte_t                reg_byte,
   input  logic [PAL_OFS_W-1:0] pal_ofs,
   output byte_t                pal_byte,
   output logic [PTR_W-1:0]     ptr,
   output logic                 ctl_phase,
   output logic                 pal_phase
);
   localparam int NREG      = 1 << REG_W;
   localparam int PAL_IDX_W = $clog2(PAL_N);

   byte_t              reg_q [NREG];
   byte_t              pal_q [PAL_B];
   logic [PTR_W-1:0]   ptr_q;
   logic               ctl_ph_q, pal_ph_q;
   byte_t              ctl_lo_q, pal_lo_q;

   logic               wr_ctl, rd_ctl, wr_pal, wr_ind, vram_acc;
   logic               ctl_second, reg_we, ind_step, pal_done;
   logic [REG_W-1:0]   reg_wa, ind_idx;
   byte_t              reg_wd;
   logic [PAL_IDX_W-1:0] pal_idx;

   assign wr_ctl = wr && addr == PORT_CTL;
   assign rd_ctl = rd && addr == PORT_CTL;
   assign wr_pal = wr && addr == PORT_PAL;
   assign wr_ind = wr && addr == PORT_IND;

   generate
      if (PTR_RD_INC) begin : g_ptr_both
         assign vram_acc = (wr || rd) && addr == PORT_VRAM;
      end else begin : g_ptr_wr_only
         assign vram_acc = wr && addr == PORT_VRAM;
      end
   endgenerate

   assign ctl_second = wr_ctl && ctl_ph_q;
   assign ind_idx    = reg_q[VREG_IND_IDX][REG_W-1:0];
   assign pal_idx    = reg_q[VREG_PAL_IDX][PAL_IDX_W-1:0];
   assign pal_done   = wr_pal && pal_ph_q;

   always_comb begin
      reg_we = 1'b0;
      reg_wa = '0;
      reg_wd = '0;
      if (ctl_second && wdata[7]) begin
         reg_we = 1'b1;
         reg_wa = wdata[REG_W-1:0];
         reg_wd = ctl_lo_q;
      end else if (wr_ind) begin
         reg_we = 1'b1;
         reg_wa = ind_idx;
         reg_wd = wdata;
      end
   end

   // the indirect index steps unless disabled, or unless the write landed on reg 17 itself
   assign ind_step = wr_ind && !reg_q[VREG_IND_IDX][7] && (int'(ind_idx) != VREG_IND_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++)  reg_q[i] <= '0;
         for (int i = 0; i < PAL_B; i++) pal_q[i] <= '0;
         ptr_q    <= '0;
         ctl_ph_q <= 1'b0;
         pal_ph_q <= 1'b0;
         ctl_lo_q <= '0;
         pal_lo_q <= '0;
      end else begin
         if (reg_we) reg_q[reg_wa] <= reg_wd;
         if (ind_step)
            reg_q[VREG_IND_IDX][REG_W-1:0] <= ind_idx + REG_W'(1);

         // control port: two-byte pairs, read clears the pair phase
         if (rd_ctl) begin
            ctl_ph_q <= 1'b0;
         end else if (wr_ctl) begin
            ctl_ph_q <= ~ctl_ph_q;
            if (!ctl_ph_q) ctl_lo_q <= wdata;
         end

         if (ctl_second && !wdata[7])
            ptr_q <= {wdata[PTR_W-9:0], ctl_lo_q};
         else if (vram_acc)
            ptr_q <= ptr_q + PTR_W'(1);

         // palette port: pairs, phase cleared by any write to the palette index register
         if (reg_we && int'(reg_wa) == VREG_PAL_IDX) begin
            pal_ph_q <= 1'b0;
         end else if (wr_pal) begin
            pal_ph_q <= ~pal_ph_q;
            if (!pal_ph_q) pal_lo_q <= wdata;
         end
         if (pal_done) begin
            pal_q[{pal_idx, 1'b0}] <= pal_lo_q;
            pal_q[{pal_idx, 1'b1}] <= wdata;
            reg_q[VREG_PAL_IDX][PAL_IDX_W-1:0] <= pal_idx + PAL_IDX_W'(1);
         end
      end
   end

   assign reg_byte  = reg_q[reg_ofs];
   assign pal_byte  = pal_q[pal_ofs];
   assign ptr       = ptr_q;
   assign ctl_phase = ctl_ph_q;
   assign pal_phase = pal_ph_q;
endmodule

// File: rtl/readback_port.sv
`timescale 1ns/1ps
module readback_port
   import snoop_pkg::*;
#(
   parameter int    FM_W      = 6,
   parameter int    REG_W     = 6,
   parameter int    PAL_OFS_W = 5,
   parameter int    PTR_W     = 14,
   parameter int    VDP_BASE  = 64,
   parameter int    PAL_BASE  = 128,
   parameter int    PTR_BASE  = 160,
   parameter byte_t PORT_SEL  = 8'h5E,
   parameter byte_t PORT_DATA = 8'h5F
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 rd,
   input  byte_t                addr,
   input  byte_t                wdata,
   output byte_t                ofs,
   output logic [FM_W-1:0]      fm_ofs,
   input  byte_t                fm_byte,
   output logic [REG_W-1:0]     reg_ofs,
   input  byte_t                reg_byte,
   output logic [PAL_OFS_W-1:0] pal_ofs,
   input  byte_t                pal_byte,
   input  logic [PTR_W-1:0]     ptr,
   output byte_t                rd_byte
);
   byte_t ofs_q, rel_reg, rel_pal;
   int    ofs_i;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ofs_q <= '0;
      else if (wr && addr == PORT_SEL)
         ofs_q <= wdata;
      else if (rd && addr == PORT_DATA)
         ofs_q <= ofs_q + 8'd1;
   end

   assign ofs_i   = int'(ofs_q);
   assign rel_reg = ofs_q - 8'(VDP_BASE);
   assign rel_pal = ofs_q - 8'(PAL_BASE);
   assign fm_ofs  = ofs_q[FM_W-1:0];
   assign reg_ofs = rel_reg[REG_W-1:0];
   assign pal_ofs = rel_pal[PAL_OFS_W-1:0];

   always_comb begin
      if (ofs_i < VDP_BASE)          rd_byte = fm_byte;
      else if (ofs_i < PAL_BASE)     rd_byte = reg_byte;
      else if (ofs_i < PTR_BASE)     rd_byte = pal_byte;
      else if (ofs_i == PTR_BASE)    rd_byte = ptr[7:0];
      else if (ofs_i == PTR_BASE+1)  rd_byte = 8'(ptr >> 8);
      else                           rd_byte = EMPTY_BYTE;
   end

   assign ofs = ofs_q;
endmodule

// File: rtl/snoop_shadow_top.sv
`timescale 1ns/1ps
module snoop_shadow_top
   import snoop_pkg::*;
#(
   parameter int    FM_W       = 6,
   parameter int    REG_W      = 6,
   parameter int    PAL_N      = 16,
   parameter int    PTR_W      = 14,
   parameter bit    PTR_RD_INC = 1'b1,
   parameter byte_t PORT_FM_IDX = 8'h7C,
   parameter byte_t PORT_FM_DAT = 8'h7D,
   parameter byte_t PORT_VRAM  = 8'h98,
   parameter byte_t PORT_CTL   = 8'h99,
   parameter byte_t PORT_PAL   = 8'h9A,
   parameter byte_t PORT_IND   = 8'h9B,
   parameter byte_t PORT_SEL   = 8'h5E,
   parameter byte_t PORT_DATA  = 8'h5F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] io_addr,
   input  logic [7:0] io_wdata,
   input  logic       io_wr,
   input  logic       io_rd,
   output logic [7:0] rd_data,
   output logic       rd_en
);
   localparam int VDP_BASE  = 1 << FM_W;
   localparam int PAL_BASE  = VDP_BASE + (1 << REG_W);
   localparam int PAL_OFS_W = $clog2(2 * PAL_N);
   localparam int PTR_BASE  = PAL_BASE + 2 * PAL_N;

   generate
      if (FM_W < 1 || FM_W > 7)
         $error("FM_W must lie in 1..7");
      if (REG_W < 5 || REG_W > 7)
         $error("REG_W must lie in 5..7 so registers 16 and 17 exist");
      if (PAL_N < 2 || (PAL_N & (PAL_N - 1)) != 0)
         $error("PAL_N must be a power of two");
      if (PTR_W < 9 || PTR_W > 16)
         $error("PTR_W must lie in 9..16");
      if ((VDP_BASE % (1 << REG_W)) != 0 || (PAL_BASE % (2 * PAL_N)) != 0)
         $error("shadow regions must be aligned");
      if (PTR_BASE + 2 > 256)
         $error("shadow space exceeds the 8-bit offset");
   endgenerate

   logic [FM_W-1:0]      fm_ofs;
   logic [REG_W-1:0]     reg_ofs;
   logic [PAL_OFS_W-1:0] pal_ofs;
   byte_t                fm_byte, reg_byte, pal_byte, ofs_q;
   logic [PTR_W-1:0]     ptr_q;
   logic                 ctl_phase, pal_phase;

   fm_shadow #(.IDX_W(FM_W), .PORT_IDX(PORT_FM_IDX), .PORT_DAT(PORT_FM_DAT)) u_fm (
      .clk(clk), .rst_n(rst_n), .wr(io_wr), .addr(io_addr), .wdata(io_wdata),
      .rd_ofs(fm_ofs), .rd_byte(fm_byte)
   );

   vdp_shadow #(
      .REG_W(REG_W), .PAL_N(PAL_N), .PTR_W(PTR_W), .PTR_RD_INC(PTR_RD_INC),
      .PORT_VRAM(PORT_VRAM), .PORT_CTL(PORT_CTL), .PORT_PAL(PORT_PAL), .PORT_IND(PORT_IND)
   ) u_vdp (
      .clk(clk), .rst_n(rst_n), .wr(io_wr), .rd(io_rd), .addr(io_addr), .wdata(io_wdata),
      .reg_ofs(reg_ofs), .reg_byte(reg_byte), .pal_ofs(pal_ofs), .pal_byte(pal_byte),
      .ptr(ptr_q), .ctl_phase(ctl_phase), .pal_phase(pal_phase)
   );

   readback_port #(
      .FM_W(FM_W), .REG_W(REG_W), .PAL_OFS_W(PAL_OFS_W), .PTR_W(PTR_W),
      .VDP_BASE(VDP_BASE), .PAL_BASE(PAL_BASE), .PTR_BASE(PTR_BASE),
      .PORT_SEL(PORT_SEL), .PORT_DATA(PORT_DATA)
   ) u_rb (
      .clk(clk), .rst_n(rst_n), .wr(io_wr), .rd(io_rd), .addr(io_addr), .wdata(io_wdata),
      .ofs(ofs_q), .fm_ofs(fm_ofs), .fm_byte(fm_byte), .reg_ofs(reg_ofs), .reg_byte(reg_byte),
      .pal_ofs(pal_ofs), .pal_byte(pal_byte), .ptr(ptr_q), .rd_byte(rd_data)
   );

   assign rd_en = io_rd && io_addr == PORT_DATA;
endmodule

// File: rtl/snoop_shadow_chk.sv
`timescale 1ns/1ps
module snoop_shadow_chk #(
   parameter int         PTR_W     = 14,
   parameter int         UNMAP     = 162,
   parameter logic [7:0] PORT_VRAM = 8'h98,
   parameter logic [7:0] PORT_CTL  = 8'h99,
   parameter logic [7:0] PORT_PAL  = 8'h9A,
   parameter logic [7:0] PORT_SEL  = 8'h5E
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       io_addr,
   input logic [7:0]       io_wdata,
   input logic             io_wr,
   input logic             io_rd,
   input logic [7:0]       rd_data,
   input logic             rd_en,
   input logic [7:0]       ofs_q,
   input logic [PTR_W-1:0] ptr_q,
   input logic             ctl_phase,
   input logic             pal_phase
);
   assert_rden_needs_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> !rd_en);

   assert_ofs_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ofs_q == $past(ofs_q) + 8'd1);

   assert_sel_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_SEL) |=> ofs_q == $past(io_wdata));

   assert_unmapped_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && int'(ofs_q) >= UNMAP) |-> rd_data == 8'hFF);

   assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_VRAM) |=> ptr_q == $past(ptr_q) + PTR_W'(1));

   assert_ctl_phase_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == PORT_CTL) |=> !ctl_phase);

   assert_ctl_phase_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_CTL) |=> ctl_phase != $past(ctl_phase));

   assert_pal_pair_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_PAL && pal_phase) |=> !pal_phase);
endmodule

bind snoop_shadow_top snoop_shadow_chk #(
   .PTR_W(PTR_W), .UNMAP(PTR_BASE + 2), .PORT_VRAM(PORT_VRAM),
   .PORT_CTL(PORT_CTL), .PORT_PAL(PORT_PAL), .PORT_SEL(PORT_SEL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
   .io_rd(io_rd), .rd_data(rd_data), .rd_en(rd_en), .ofs_q(ofs_q), .ptr_q(ptr_q),
   .ctl_phase(ctl_phase), .pal_phase(pal_phase)
);

// File: tb/snoop_shadow_top_tb.sv
`timescale 1ns/1ps
module snoop_shadow_top_tb;
   localparam logic [7:0] P_SEL = 8'h5E, P_DAT = 8'h5F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = '0, io_wdata = '0;
   logic       io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] rd_data;
   logic       rd_en;

   int n_cmp = 0, n_bad = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2.5 clk = ~clk;

   snoop_shadow_top u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .rd_data(rd_data), .rd_en(rd_en)
   );

   task automatic bus(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
      @(posedge clk); #1;
      io_wr = 1'b0; io_rd = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus(1'b1, 1'b0, a, d);
   endtask

   // read the readback port, pushing the expected byte for the monitor
   task automatic rd_next(input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      bus(1'b0, 1'b1, P_DAT, 8'h00);
   endtask

   task automatic chk(input logic [7:0] o, input logic [7:0] e, input string t);
      wr(P_SEL, o);
      rd_next(e, t);
   endtask

   // monitor: samples mid-cycle, pops the scoreboard on each readback
   always @(negedge clk) begin
      if (rst_n && io_rd) begin
         if (io_addr == P_DAT) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL unexpected readback: actual %02h expected none", rd_data);
            end else begin
               automatic logic [7:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               if (!rd_en || rd_data !== e) begin
                  n_bad++;
                  $display("FAIL %s: actual en=%0b data=%02h expected en=1 data=%02h", t, rd_en, rd_data, e);
               end
            end
         end else begin
            n_cmp++;
            if (rd_en !== 1'b0) begin
               n_bad++;
               $display("FAIL R10: actual en=%0b expected en=0 on port %02h", rd_en, io_addr);
            end
         end
      end
   end

   task automatic finish_run();
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, first read without select uses offset 0
      rd_next(8'h00, "R1 offset0");
      chk(8'h40, 8'h00, "R1 vreg0");
      chk(8'h80, 8'h00, "R1 pal");
      chk(8'hA0, 8'h00, "R1 ptr lo");
      chk(8'hA1, 8'h00, "R1 ptr hi");

      // R2: index/data pairs, last write wins, out of range index ignored
      wr(8'h7C, 8'h10); wr(8'h7D, 8'h55); wr(8'h7D, 8'hAA);
      chk(8'h10, 8'hAA, "R2 last value");
      wr(8'h7C, 8'h30); wr(8'h7D, 8'h31);
      chk(8'h30, 8'h31, "R2 second reg");
      wr(8'h7C, 8'h80); wr(8'h7D, 8'h99);
      chk(8'h00, 8'h00, "R2 index>=64 ignored");
      chk(8'h10, 8'hAA, "R2 untouched");

      // R3: register write through control pair
      wr(8'h99, 8'h3C); wr(8'h99, 8'h87);
      chk(8'h47, 8'h3C, "R3 vreg7");

      // R4: pointer load, bit 6 of second byte ignored
      wr(8'h99, 8'h34); wr(8'h99, 8'h52);
      chk(8'hA0, 8'h34, "R4 ptr lo");
      chk(8'hA1, 8'h12, "R4 ptr hi");

      // R6: stepping by writes and reads, then wrap
      wr(8'h98, 8'h01); wr(8'h98, 8'h02); wr(8'h98, 8'h03);
      bus(1'b0, 1'b1, 8'h98, 8'h00);
      chk(8'hA0, 8'h38, "R6 ptr step");
      chk(8'hA1, 8'h12, "R6 ptr hi kept");
      wr(8'h99, 8'hFF); wr(8'h99, 8'h3F);
      wr(8'h98, 8'h00);
      chk(8'hA0, 8'h00, "R6 wrap lo");
      chk(8'hA1, 8'h00, "R6 wrap hi");

      // R5: read of control port restarts the pair
      wr(8'h99, 8'h11);
      bus(1'b0, 1'b1, 8'h99, 8'h00);
      wr(8'h99, 8'h22); wr(8'h99, 8'h85);
      chk(8'h45, 8'h22, "R5 phase reset");
      chk(8'hA0, 8'h00, "R5 ptr untouched");

      // R7: palette pairs, index step and wrap, phase cleared by reg16 write
      wr(8'h99, 8'h0E); wr(8'h99, 8'h90);
      wr(8'h9A, 8'h71); wr(8'h9A, 8'h02);
      wr(8'h9A, 8'h11); wr(8'h9A, 8'h03);
      chk(8'h50, 8'h00, "R7 index wrap");
      wr(8'h9A, 8'h44);
      wr(8'h99, 8'h02); wr(8'h99, 8'h90);
      wr(8'h9A, 8'h55); wr(8'h9A, 8'h06);
      chk(8'h84, 8'h55, "R7 entry2 first");
      chk(8'h85, 8'h06, "R7 entry2 second");
      chk(8'h50, 8'h03, "R7 index step");

      // R8: indirect port with and without auto step
      wr(8'h99, 8'h20); wr(8'h99, 8'h91);
      wr(8'h9B, 8'hA1); wr(8'h9B, 8'hA2);
      chk(8'h60, 8'hA1, "R8 vreg32");
      chk(8'h61, 8'hA2, "R8 vreg33");
      chk(8'h51, 8'h22, "R8 index stepped");
      wr(8'h99, 8'h85); wr(8'h99, 8'h91);
      wr(8'h9B, 8'h5A); wr(8'h9B, 8'h5B);
      chk(8'h45, 8'h5B, "R8 fixed index");
      chk(8'h51, 8'h85, "R8 index held");

      // R9: sequential readback, region edges, unmapped, offset wrap
      wr(P_SEL, 8'h9C);
      rd_next(8'h71, "R9 seq 9C");
      rd_next(8'h02, "R9 seq 9D");
      rd_next(8'h11, "R9 seq 9E");
      rd_next(8'h03, "R9 seq 9F");
      rd_next(8'h00, "R9 seq A0");
      rd_next(8'h00, "R9 seq A1");
      rd_next(8'hFF, "R9 unmapped A2");
      wr(P_SEL, 8'hFF);
      rd_next(8'hFF, "R9 offset FF");
      rd_next(8'h00, "R9 offset wrap");

      // R10: unrelated ports and writes to the readback port leave shadow intact
      wr(8'h7E, 8'h77); wr(8'h97, 8'h66); wr(P_DAT, 8'h12);
      bus(1'b0, 1'b1, 8'h7C, 8'h00);
      bus(1'b0, 1'b1, P_SEL, 8'h00);
      chk(8'h10, 8'hAA, "R10 fm kept");
      chk(8'h47, 8'h3C, "R10 vreg kept");
      chk(8'hA0, 8'h00, "R10 ptr kept");

      repeat (4) @(posedge clk);
      finish_run();
   end
endmodule